// File: doc/BRIEF.md
# Repetition-Counted PWM Timer

This block is an up-counting timer that drives one pulse-width-modulated output. A prescaler divides the input clock down to a counting tick. The counter runs from zero up to a programmed period value and then wraps. While the count is below a programmed compare value the output is high; otherwise it is low. A repetition down-counter allows several identical pulses to run back to back. An update pulse is raised only once the programmed number of pulses has completed. That pulse is the point where a DMA engine or software can supply the next segment.

The period, compare and repetition values are written into shadow (preload) registers. They reach the active copies only at an update event, so a segment can be rewritten while it is still playing without disturbing it. Software can force an update at any time by writing the event register. The forced update loads the shadow values at once and restarts the counter.

Top module: `pwm_rep_timer`

## Requirements
- R1: With prescaler value P, every counter value lasts exactly P+1 input clock cycles while counting is enabled.
- R2: With active period value N, the counter steps 0,1,…,N and then returns to 0, so one pulse lasts (N+1)(P+1) clock cycles.
- R3: While the output is enabled, it is high exactly while the count is below the active compare value C. C = 0 gives a constantly low output, and C > N gives a constantly high output.
- R4: With active repetition value K, an update event occurs after K+1 complete pulses. It appears on `upd_o` as a one-cycle pulse during which the count is 0. The interval between updates is therefore (N+1)(P+1)(K+1) cycles.
- R5: Writes to the period (address 2), compare (address 3) and repetition (address 4) registers do not change the running segment. They take effect from the next update event.
- R6: Writing 1 to bit 0 of the event register (address 5) causes the following:
  - the shadow values load at that clock edge;
  - the counter and prescaler restart from 0;
  - `upd_o` pulses in the next cycle;
  - the register reads back 0.
- R7: The output is driven high only when both the main output enable (control bit 1) and the channel enable (control bit 2) are set. Otherwise it stays low.
- R8: When the run bit (control bit 0, at address 0) is clear:
  - the count holds its value;
  - the output is low;
  - no update event occurs except a forced one.
- R9: After reset, every register reads 0, the count (read-only, address 6) is 0, and the output and `upd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, shared by reads and writes |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational from `addr` |
| pwm_o | output | 1 | PWM output pin |
| upd_o | output | 1 | One-cycle update-event pulse |

## Verification
The bench targets the following corner cases:

- **Compare extremes.** A compare of 0 and a compare above the period show whether the comparison is strict. A design using `<=` would emit a spurious one-tick pulse at C = 0.
- **Mid-segment rewrite.** Rewriting the period in the middle of a running segment exposes a design without shadowing. Such a design would cut the current segment short.
- **Off-by-one in the repetition count.** The measured update interval catches a repetition counter that stops at one pulse too many or too few. It also catches a prescaler that divides by P instead of P+1.
- **Gating and hold.** The tests confirm that clearing either output enable silences the pin. They also confirm that clearing the run bit freezes the count rather than resetting it.

// File: rtl/pwm_rep_pkg.sv
package pwm_rep_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_PSC  = 3'd1,
    RA_PER  = 3'd2,
    RA_CMP  = 3'd3,
    RA_REP  = 3'd4,
    RA_EVT  = 3'd5,
    RA_CNT  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic chan_en;
    logic main_oe;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] pc_q, pc_d;
  logic             at_lim;

  assign at_lim = (pc_q >= div);
  assign tick   = run && !restart && at_lim;

  always_comb begin
    pc_d = pc_q;
    if (restart)  pc_d = '0;
    else if (run) pc_d = at_lim ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] per_pre,
  input  logic [CNT_W-1:0] cmp_pre,
  input  logic [REP_W-1:0] rep_pre,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, cmp_q, cmp_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             upd_q, upd_d, do_load;

  always_comb begin
    cnt_d   = cnt_q;
    per_d   = per_q;
    cmp_d   = cmp_q;
    rep_d   = rep_q;
    do_load = 1'b0;
    if (force_upd) begin
      cnt_d   = '0;
      do_load = 1'b1;
    end else if (tick) begin
      if (cnt_q == per_q) begin
        cnt_d = '0;
        if (rep_q == '0) do_load = 1'b1;
        else             rep_d   = rep_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (do_load) begin
      per_d = per_pre;
      cmp_d = cmp_pre;
      rep_d = rep_pre;
    end
    upd_d = do_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      cmp_q <= '0;
      rep_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
      rep_q <= rep_d;
      upd_q <= upd_d;
    end
  end

  assign cnt     = cnt_q;
  assign cmp_act = cmp_q;
  assign upd     = upd_q;

  AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cnt_q == '0)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q); // R2
  AST_ACT_AT_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_q) || !$stable(cmp_q)) |-> upd_q); // R5
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic             main_oe,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             pwm
);
  logic raw;
  assign raw = run && (cnt < cmp);
  assign pwm = raw && main_oe && chan_en;
endmodule

// File: rtl/pwm_rep_timer.sv
module pwm_rep_timer
  import pwm_rep_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_o,
  output logic              upd_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] per_q, per_d, cmp_q, cmp_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             force_upd, tick;
  logic [CNT_W-1:0] cnt, cmp_act;

  assign force_upd = wr_en && (addr == RA_EVT) && wdata[0];

  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    per_d  = per_q;
    cmp_d  = cmp_q;
    rep_d  = rep_q;
    if (wr_en) begin
      case (addr)
        RA_CTRL: ctrl_d = ctrl_t'(wdata[2:0]);
        RA_PSC:  psc_d  = wdata[PSC_W-1:0];
        RA_PER:  per_d  = wdata[CNT_W-1:0];
        RA_CMP:  cmp_d  = wdata[CNT_W-1:0];
        RA_REP:  rep_d  = wdata[REP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      per_q  <= '0;
      cmp_q  <= '0;
      rep_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      psc_q  <= psc_d;
      per_q  <= per_d;
      cmp_q  <= cmp_d;
      rep_q  <= rep_d;
    end
  end

  always_comb begin
    case (addr)
      RA_CTRL: rdata = DATA_W'(ctrl_q);
      RA_PSC:  rdata = DATA_W'(psc_q);
      RA_PER:  rdata = DATA_W'(per_q);
      RA_CMP:  rdata = DATA_W'(cmp_q);
      RA_REP:  rdata = DATA_W'(rep_q);
      RA_CNT:  rdata = DATA_W'(cnt);
      default: rdata = '0;
    endcase
  end

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .restart(force_upd),
    .div(psc_q), .tick(tick)
  );

  pwm_period_core #(.CNT_W(CNT_W), .REP_W(REP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd),
    .per_pre(per_q), .cmp_pre(cmp_q), .rep_pre(rep_q),
    .cnt(cnt), .cmp_act(cmp_act), .upd(upd_o)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .run(ctrl_q.run), .main_oe(ctrl_q.main_oe), .chan_en(ctrl_q.chan_en),
    .cnt(cnt), .cmp(cmp_act), .pwm(pwm_o)
  );

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_q.main_oe && ctrl_q.chan_en) |-> !pwm_o); // R7
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !pwm_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !force_upd) |=> $stable(cnt)); // R8
  AST_FORCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> upd_o); // R6
endmodule

// File: tb/sim_pwm_rep_timer.sv
module sim_pwm_rep_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        pwm_o, upd_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pwm_rep_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_o(pwm_o), .upd_o(upd_o)
  );

  // {prescale, period, compare, repeat}
  localparam logic [63:0] VEC [5] = '{
    {16'd0, 16'd3, 16'd1, 16'd0},
    {16'd1, 16'd4, 16'd2, 16'd2},
    {16'd0, 16'd5, 16'd0, 16'd1},
    {16'd2, 16'd2, 16'd5, 16'd0},
    {16'd0, 16'd9, 16'd9, 16'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  // counts cycles from the current (pulse) cycle until the next update pulse
  task automatic measure(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      hi += int'(pwm_o);
      n++;
      @(negedge clk);
    end while (!upd_o && n < 5000);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n, hi, v, v2, p, per, c, k, exp_hi;
    wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(3'd2, v); check("R9 period reg", v, 0);
    rd(3'd6, v); check("R9 count", v, 0);
    check("R9 outputs", int'(pwm_o) + int'(upd_o), 0);

    // R1 R2 R3 R4 table of segments
    wr(3'd0, 16'd7);
    foreach (VEC[i]) begin
      p = int'(VEC[i][63:48]); per = int'(VEC[i][47:32]);
      c = int'(VEC[i][31:16]); k = int'(VEC[i][15:0]);
      wr(3'd1, VEC[i][63:48]); wr(3'd2, VEC[i][47:32]);
      wr(3'd3, VEC[i][31:16]); wr(3'd4, VEC[i][15:0]);
      wr(3'd5, 16'd1);
      measure(n, hi);
      check("R1 R2 R4 update interval", n, (per + 1) * (p + 1) * (k + 1));
      exp_hi = ((c < per + 1) ? c : per + 1) * (p + 1) * (k + 1);
      check("R3 high cycles", hi, exp_hi);
    end

    // R6 force update: pulse, count restarts, self-clearing bit
    wr(3'd1, 16'd3); wr(3'd2, 16'd5); wr(3'd4, 16'd0);
    repeat (7) @(negedge clk);
    wr(3'd5, 16'd1);
    check("R6 update pulse", int'(upd_o), 1);
    rd(3'd6, v); check("R6 count restart", v, 0);
    rd(3'd5, v); check("R6 event reads 0", v, 0);

    // R5 mid-segment rewrite of period
    wr(3'd1, 16'd0); wr(3'd2, 16'd7); wr(3'd3, 16'd3); wr(3'd4, 16'd1);
    wr(3'd5, 16'd1);
    n = 0; hi = 0;
    do begin
      hi += int'(pwm_o);
      n++;
      if (n == 2) begin wr_en = 1'b1; addr = 3'd2; wdata = 16'd3; end
      else wr_en = 1'b0;
      @(negedge clk);
    end while (!upd_o && n < 5000);
    check("R5 running segment kept", n, 16);
    check("R5 running high kept", hi, 6);
    measure(n, hi);
    check("R5 new period applied", n, 8);
    check("R5 new high", hi, 6);

    // R7 output gating
    wr(3'd0, 16'd3);
    wr(3'd5, 16'd1);
    measure(n, hi); check("R7 channel disabled", hi, 0);
    wr(3'd0, 16'd5);
    wr(3'd5, 16'd1);
    measure(n, hi); check("R7 main disabled", hi, 0);

    // R8 counter disabled: hold, low, no update
    wr(3'd0, 16'd7);
    repeat (3) @(negedge clk);
    wr(3'd0, 16'd6);
    rd(3'd6, v);
    n = 0; hi = 0;
    for (int j = 0; j < 20; j++) begin
      n += int'(upd_o); hi += int'(pwm_o);
      @(negedge clk);
    end
    rd(3'd6, v2);
    check("R8 count held", v2, v);
    check("R8 output low", hi, 0);
    check("R8 no update", n, 0);

    finish_run();
  end
endmodule